// File: doc/BRIEF.md
# Firmware Hub Read Target

This block is the target side of a read transaction on a 4-bit multiplexed firmware-hub bus. It watches the bus for the start of a host read cycle. It keeps going only when the cycle carries its own strap identity. It then collects a 28-bit address and a transfer size. After the host hands the bus over, the block answers with wait, sync and data nibbles for one, sixteen or thirty-two bytes.

The bidirectional nibble lines appear as a separate input, an output and an output-enable. Read data comes from a small internal byte array indexed by the low address bits. A simple write port loads the array. Bursts step through consecutive addresses and never leave the aligned block that the burst size defines.

Top module: `fwh_read_target`

## Requirements
- R1: A cycle starts only on a rising clock edge where `frame_n` is 0 and `nib_in` is 4'b1101. The same nibble with `frame_n` at 1 starts nothing.
- R2: The nibble after the start is compared with `id_strap`. On a mismatch the block returns to idle and keeps `nib_oe` at 0 for the whole cycle.
- R3: The next seven nibbles form the address, most significant nibble first. Only the low `MEM_AW` address bits select a byte, so reads that differ only in the upper bits return the same data.
- R4: The nibble after the address selects the length: 4'b0000 is 1 byte, 4'b0100 is 16 bytes and 4'b0101 is 32 bytes.
- R5: During the host turnaround clock (cycle 11) and the ownership clock after it (cycle 12), `nib_oe` stays 0. The first driven nibble appears in cycle 13.
- R6: Each byte is sent as 4'b0101 for two clocks, then 4'b0000 for one clock, then the low data nibble, then the high data nibble, with `nib_oe` at 1 throughout.
- R7: The five-clock group is sent once for each byte of the selected length, with no gap between groups.
- R8: After the last high nibble the block drives 4'b1111 for one clock, then sets `nib_oe` to 0 in the next clock.
- R9: Each byte of a burst comes from the address one above the previous byte. The count wraps inside the aligned 16-byte block (length 16) or 32-byte block (length 32).
- R10: A length nibble other than the three valid codes, or a start nibble other than 4'b1101, returns the block to idle with `nib_oe` held at 0.
- R11: While `rst_n` is 0 at a clock edge, the block goes idle, with `nib_oe` at 0 and `nib_out` at 4'b1111.
- R12: A clock edge with `ld_en` at 1 writes `ld_data` into the array at `ld_addr`, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Cycle start strobe, active low |
| nib_in | input | 4 | Nibble bus as seen from the line |
| id_strap | input | 4 | Identity this target answers to |
| ld_en | input | 1 | Array load enable |
| ld_addr | input | MEM_AW | Array load address |
| ld_data | input | 8 | Array load byte |
| nib_out | output | 4 | Nibble the target drives |
| nib_oe | output | 1 | Target owns and drives the nibble bus |

## Verification
The assertions assume that the host sends a start only while the target is idle. They also assume the host holds `frame_n` high for the rest of that cycle, so no new start overlaps an answer in progress. The stimulus lowers `frame_n` only in the start clock. It returns `nib_in` to 4'b1111 during and after the turnaround, and it waits for the release clock before opening the next cycle. Rejected cycles are given enough idle clocks to show that the block never takes the bus.

// File: rtl/fwh_pkg.sv
// Package: shared encodings and helpers for the firmware-hub read target.
// Assumes a 4-bit nibble bus and a 28-bit address carried as seven nibbles.
package fwh_pkg;

    localparam logic [3:0] START_RD   = 4'b1101;
    localparam logic [3:0] NIB_WAIT   = 4'b0101;
    localparam logic [3:0] NIB_READY  = 4'b0000;
    localparam logic [3:0] NIB_TURN   = 4'b1111;
    localparam logic [3:0] LEN_ONE    = 4'b0000;
    localparam logic [3:0] LEN_SIXTEEN = 4'b0100;
    localparam logic [3:0] LEN_THIRTY2 = 4'b0101;
    localparam int         ADDR_NIBS  = 7;
    localparam int         LEFT_W     = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_SIZE,
        ST_HTAR,
        ST_OWN,
        ST_WAIT,
        ST_SYNC,
        ST_DLO,
        ST_DHI,
        ST_ETAR
    } fwh_state_e;

    // True for the three supported length codes.
    function automatic logic len_ok(input logic [3:0] code);
        return (code == LEN_ONE) || (code == LEN_SIXTEEN) || (code == LEN_THIRTY2);
    endfunction

    // Bytes remaining after the first one, for a valid length code.
    function automatic logic [LEFT_W-1:0] extra_bytes(input logic [3:0] code);
        case (code)
            LEN_SIXTEEN: return LEFT_W'(15);
            LEN_THIRTY2: return LEFT_W'(31);
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/fwh_byte_store.sv
// Module: byte array the target reads from.
// Write port is synchronous; read port is combinational so data follows the
// pointer in the same clock. No reset: contents are loaded before use.
module fwh_byte_store #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    // Store one byte per enabled clock.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present the addressed byte.
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/fwh_burst_addr.sv
// Module: address capture and burst byte pointer.
// Shifts address nibbles in MSB first and keeps only the low AW bits, so the
// upper address bits never reach the array. On load it copies the captured
// address into the pointer and latches the wrap size. Each step advances the
// pointer by one inside the aligned 16- or 32-byte block. Assumes AW >= 5.
module fwh_burst_addr
    import fwh_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [3:0]    nib_in,
    input  logic          load_en,
    input  logic          load_wide,
    input  logic          step_en,
    output logic [AW-1:0] cur_addr
);
    localparam int LOW_WRAP_W  = 4;
    localparam int HIGH_WRAP_W = 5;

    logic [AW-1:0] cap_q;
    logic [AW-1:0] ptr_q;
    logic          wide_q;
    logic [AW-1:0] wrap_mask;
    logic [AW-1:0] ptr_next;

    // Collect address nibbles, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (shift_en) begin
            cap_q <= {cap_q[AW-5:0], nib_in};
        end
    end

    // Choose which low bits roll over during a burst.
    generate
        if (AW > HIGH_WRAP_W) begin : g_wide_store
            assign wrap_mask = wide_q ? {{(AW-HIGH_WRAP_W){1'b0}}, {HIGH_WRAP_W{1'b1}}}
                                      : {{(AW-LOW_WRAP_W){1'b0}}, {LOW_WRAP_W{1'b1}}};
        end else begin : g_narrow_store
            assign wrap_mask = wide_q ? {AW{1'b1}}
                                      : {{(AW-LOW_WRAP_W){1'b0}}, {LOW_WRAP_W{1'b1}}};
        end
    endgenerate

    // Increment inside the block, keeping the block bits fixed.
    assign ptr_next = (ptr_q & ~wrap_mask) | ((ptr_q + AW'(1)) & wrap_mask);

    // Load the start pointer or advance it after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            wide_q <= 1'b0;
        end else if (load_en) begin
            ptr_q  <= cap_q;
            wide_q <= load_wide;
        end else if (step_en) begin
            ptr_q  <= ptr_next;
        end
    end

    assign cur_addr = ptr_q;

endmodule

// File: rtl/fwh_read_fsm.sv
// Module: cycle sequencer for the read target.
// Decodes start, identity, address and length, then sends wait, sync and
// data nibbles for every byte and closes with a turnaround. Outputs are
// decoded from the registered state, so each nibble holds a full clock.
// Assumes the host opens a new cycle only while this block is idle.
module fwh_read_fsm
    import fwh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [3:0] nib_in,
    input  logic [3:0] id_strap,
    input  logic [7:0] rd_data,
    output logic       shift_en,
    output logic       load_en,
    output logic       load_wide,
    output logic       step_en,
    output logic [3:0] nib_out,
    output logic       nib_oe,
    output fwh_state_e state
);
    localparam int CNT_W = $clog2(ADDR_NIBS);

    fwh_state_e        state_q, state_d;
    logic [CNT_W-1:0]  nib_cnt_q, nib_cnt_d;
    logic              wait_cnt_q, wait_cnt_d;
    logic [LEFT_W-1:0] left_q, left_d;

    // Work out the next state and counter values.
    always_comb begin
        state_d    = state_q;
        nib_cnt_d  = nib_cnt_q;
        wait_cnt_d = wait_cnt_q;
        left_d     = left_q;
        shift_en   = 1'b0;
        load_en    = 1'b0;
        step_en    = 1'b0;
        load_wide  = (nib_in == LEN_THIRTY2);
        case (state_q)
            ST_IDLE: begin
                if (!frame_n && nib_in == START_RD) begin
                    state_d = ST_ID;
                end
            end
            ST_ID: begin
                nib_cnt_d = '0;
                state_d   = (nib_in == id_strap) ? ST_ADDR : ST_IDLE;
            end
            ST_ADDR: begin
                shift_en  = 1'b1;
                nib_cnt_d = nib_cnt_q + CNT_W'(1);
                if (nib_cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
                    state_d = ST_SIZE;
                end
            end
            ST_SIZE: begin
                if (len_ok(nib_in)) begin
                    load_en = 1'b1;
                    left_d  = extra_bytes(nib_in);
                    state_d = ST_HTAR;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_HTAR: state_d = ST_OWN;
            ST_OWN: begin
                wait_cnt_d = 1'b0;
                state_d    = ST_WAIT;
            end
            ST_WAIT: begin
                wait_cnt_d = ~wait_cnt_q;
                if (wait_cnt_q) begin
                    state_d = ST_SYNC;
                end
            end
            ST_SYNC: state_d = ST_DLO;
            ST_DLO:  state_d = ST_DHI;
            ST_DHI: begin
                if (left_q == '0) begin
                    state_d = ST_ETAR;
                end else begin
                    left_d     = left_q - LEFT_W'(1);
                    step_en    = 1'b1;
                    wait_cnt_d = 1'b0;
                    state_d    = ST_WAIT;
                end
            end
            ST_ETAR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            nib_cnt_q  <= '0;
            wait_cnt_q <= 1'b0;
            left_q     <= '0;
        end else begin
            state_q    <= state_d;
            nib_cnt_q  <= nib_cnt_d;
            wait_cnt_q <= wait_cnt_d;
            left_q     <= left_d;
        end
    end

    // Decode the driven nibble and enable from the current state.
    always_comb begin
        nib_out = NIB_TURN;
        nib_oe  = 1'b0;
        case (state_q)
            ST_WAIT: begin nib_out = NIB_WAIT;     nib_oe = 1'b1; end
            ST_SYNC: begin nib_out = NIB_READY;    nib_oe = 1'b1; end
            ST_DLO:  begin nib_out = rd_data[3:0]; nib_oe = 1'b1; end
            ST_DHI:  begin nib_out = rd_data[7:4]; nib_oe = 1'b1; end
            ST_ETAR: begin nib_out = NIB_TURN;     nib_oe = 1'b1; end
            default: begin nib_out = NIB_TURN;     nib_oe = 1'b0; end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/fwh_read_target.sv
// Module: top of the firmware-hub read target.
// Joins the sequencer, the address/pointer unit and the byte array. The
// nibble bus is split into input, output and enable; the caller resolves
// the shared lines. The load port only fills the array.
module fwh_read_target
    import fwh_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        nib_in,
    input  logic [3:0]        id_strap,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    output logic [3:0]        nib_out,
    output logic              nib_oe
);
    logic              shift_en;
    logic              load_en;
    logic              load_wide;
    logic              step_en;
    logic [MEM_AW-1:0] cur_addr;
    logic [7:0]        rd_data;
    fwh_state_e        fsm_state;

    fwh_read_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .nib_in    (nib_in),
        .id_strap  (id_strap),
        .rd_data   (rd_data),
        .shift_en  (shift_en),
        .load_en   (load_en),
        .load_wide (load_wide),
        .step_en   (step_en),
        .nib_out   (nib_out),
        .nib_oe    (nib_oe),
        .state     (fsm_state)
    );

    fwh_burst_addr #(.AW(MEM_AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .nib_in    (nib_in),
        .load_en   (load_en),
        .load_wide (load_wide),
        .step_en   (step_en),
        .cur_addr  (cur_addr)
    );

    fwh_byte_store #(.AW(MEM_AW)) u_store (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/fwh_read_target_chk.sv
// Module: property checker for the read target, attached with bind.
// Assumes the host does not open a cycle while an answer is in progress.
module fwh_read_target_chk
    import fwh_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_n,
    input logic [3:0]    nib_in,
    input logic [3:0]    id_strap,
    input logic [3:0]    nib_out,
    input logic          nib_oe,
    input fwh_state_e    state,
    input logic [AW-1:0] cur_addr
);
    // Idle stays idle unless a proper start is seen.
    assert_no_false_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (frame_n || nib_in != START_RD)) |=> state == ST_IDLE);

    // A foreign identity sends the block back to idle without driving.
    assert_foreign_id_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID && nib_in != id_strap) |=> (state == ST_IDLE && !nib_oe));

    // The first driven nibble is a wait, right after the ownership clock.
    assert_first_drive_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nib_oe) |-> (nib_out == NIB_WAIT && $past(state) == ST_OWN));

    // Sync is always preceded by exactly two wait clocks.
    assert_two_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SYNC |-> ($past(state) == ST_WAIT && $past(state, 2) == ST_WAIT
                              && $past(state, 3) != ST_WAIT));

    // The bus is released only after a one-clock 1111 turnaround.
    assert_release_after_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nib_oe) |-> $past(nib_out) == NIB_TURN);

    // Between bytes of a burst the 32-byte block bits never change.
    assert_burst_in_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state) == ST_DHI)
            |-> cur_addr[AW-1:5] == $past(cur_addr[AW-1:5]));

    // An unsupported length code ends the cycle.
    assert_bad_len_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SIZE && !len_ok(nib_in)) |=> state == ST_IDLE);

endmodule

bind fwh_read_target fwh_read_target_chk #(.AW(MEM_AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .nib_in   (nib_in),
    .id_strap (id_strap),
    .nib_out  (nib_out),
    .nib_oe   (nib_oe),
    .state    (fsm_state),
    .cur_addr (cur_addr)
);

// File: tb/fwh_read_target_tb.sv
// Directed bench for the read target: one task per scenario.
module fwh_read_target_tb_top;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [3:0] MY_ID = 4'h3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_n = 1'b1;
    logic [3:0]    nib_in = 4'hF;
    logic [3:0]    id_strap = MY_ID;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic [3:0]    nib_out;
    logic          nib_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    fwh_read_target #(.MEM_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
        .id_strap(id_strap), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .nib_out(nib_out), .nib_oe(nib_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R12: write one byte through the load port.
    task automatic load_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        model[a] = d;
    endtask

    // Send a header; answer expected or not; check every clock.
    task automatic run_read(input logic [3:0] id, input logic [27:0] addr,
                            input logic [3:0] sz, input bit answer, input string req);
        int a;
        int nbytes;
        int mask;
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            check(nib_oe == 1'b0, "R5", "oe during header", nib_oe, 0);
            frame_n = (j == 1) ? 1'b0 : 1'b1;
            if (j == 1)       nib_in = 4'b1101;
            else if (j == 2)  nib_in = id;
            else if (j <= 9)  nib_in = addr[27-4*(j-3) -: 4];
            else              nib_in = sz;
        end
        @(negedge clk);
        check(nib_oe == 1'b0, "R5", "oe in cycle 11", nib_oe, 0);
        nib_in = 4'hF;
        @(negedge clk);
        check(nib_oe == 1'b0, "R5", "oe in cycle 12", nib_oe, 0);
        if (!answer) begin
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                check(nib_oe == 1'b0, req, "oe after rejected cycle", nib_oe, 0);
            end
            return;
        end
        nbytes = (sz == 4'b0101) ? 32 : (sz == 4'b0100) ? 16 : 1;
        mask   = (sz == 4'b0101) ? 31 : 15;
        a      = int'(addr[AW-1:0]);
        for (int b = 0; b < nbytes; b++) begin
            @(negedge clk);
            check(nib_oe && nib_out == 4'h5, "R6", "wait nibble 1", {nib_oe, nib_out}, 5'h15);
            @(negedge clk);
            check(nib_oe && nib_out == 4'h5, "R6", "wait nibble 2", {nib_oe, nib_out}, 5'h15);
            @(negedge clk);
            check(nib_oe && nib_out == 4'h0, "R6", "sync nibble", {nib_oe, nib_out}, 5'h10);
            @(negedge clk);
            check(nib_oe && nib_out == model[a][3:0], req, "low data nibble",
                  nib_out, model[a][3:0]);
            @(negedge clk);
            check(nib_oe && nib_out == model[a][7:4], req, "high data nibble",
                  nib_out, model[a][7:4]);
            a = (a & ~mask) | ((a + 1) & mask);
        end
        @(negedge clk);
        check(nib_oe && nib_out == 4'hF, "R8", "closing turnaround", {nib_oe, nib_out}, 5'h1F);
        @(negedge clk);
        check(nib_oe == 1'b0, "R8", "release", nib_oe, 0);
    endtask

    // R11: state right after reset.
    task automatic t_reset;
        @(negedge clk);
        check(nib_oe == 1'b0 && nib_out == 4'hF, "R11", "reset outputs",
              {nib_oe, nib_out}, 5'h0F);
    endtask

    // R1 / R10: start nibble variants that must not open a cycle.
    task automatic t_bad_start(input bit frame_hi, input logic [3:0] code, input string req);
        @(negedge clk);
        frame_n = frame_hi; nib_in = code;
        @(negedge clk);
        frame_n = 1'b1; nib_in = MY_ID;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            nib_in = (k == 8) ? 4'h0 : 4'hF;
            check(nib_oe == 1'b0, req, "oe after non-start", nib_oe, 0);
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) load_byte(i, 8'((i * 37 + 11) ^ 8'h5C));

        run_read(MY_ID, 28'h0000_007, 4'b0000, 1'b1, "R4");          // single byte
        run_read(MY_ID, 28'h0000_01B, 4'b0100, 1'b1, "R9");          // 16 with wrap
        run_read(MY_ID, 28'h0000_02E, 4'b0101, 1'b1, "R7");          // 32 with wrap
        run_read(MY_ID, 28'hABC_DE05, 4'b0000, 1'b1, "R3");          // upper bits ignored
        run_read(4'hA,  28'h0000_005, 4'b0000, 1'b0, "R2");          // foreign id
        run_read(MY_ID, 28'h0000_005, 4'b0010, 1'b0, "R10");         // bad length
        t_bad_start(1'b0, 4'b1100, "R10");
        t_bad_start(1'b1, 4'b1101, "R1");
        load_byte(9, 8'hA5);
        run_read(MY_ID, 28'h0000_009, 4'b0000, 1'b1, "R12");
        run_read(MY_ID, 28'h0000_030, 4'b0100, 1'b1, "R9");          // aligned 16

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule